// File: doc/BRIEF.md
# Conditional Jump and Interrupt Entry Unit

This unit decides and performs every change of program flow for a small 4-bit processor with a 12-bit address space. It handles three cases. A jump request tests one condition and loads a new program counter. A subroutine call runs the same test and, when the condition holds, first has an external stack engine save the 12-bit return address as three nybbles. An accepted interrupt saves the address of the next opcode and then reads a 12-bit vector from the three highest memory nybbles.

A single condition nybble covers every branch flavour. Its low three bits pick one bit of the 8-bit status word, with S1 in the upper half and S0 in the lower half. Its top bit inverts the test. Status bit 7 is forced to one inside the unit, so one encoding always branches and its inverse never does. There is no return path in this block. A return is a stack pop into the program counter, which the stack engine and fetch logic perform.

The vector read port is combinational: the data for the presented address is returned in the same cycle. The asynchronous active-low reset is released through a two-stage synchronizer. The block therefore starts accepting requests on the third rising edge after the reset input goes high.

Top module: `flow_unit`

## Requirements
- R1: With condition bit 3 at 0, a request branches exactly when the status bit indexed by condition bits 2:0 is 1. Status bits 7:4 are S1 and bits 3:0 are S0, so 4'b0001 tests S0 bit 1 (zero flag).
- R2: With condition bit 3 at 1, the test is inverted. A request branches exactly when the indexed status bit is 0, so 4'b1001 branches on a clear zero flag.
- R3: Status bit 7 reads as 1 whatever `status_i[7]` carries. Condition 4'b0111 always branches and condition 4'b1111 never branches.
- R4: A branching jump request presents `target_i` on `pc_o` with `pc_load_o` high for exactly the cycle after the request. A non-branching jump loads nothing, pushes nothing and leaves `pc_o` unchanged.
- R5: A branching call raises `push_req_o`, with `push_addr_o` equal to the `next_pc_i` captured at the request, until the cycle of `push_ack_i`. In the cycle after that ack, `pc_load_o` is high and `pc_o` equals the call target. A non-branching call never raises `push_req_o`.
- R6: An interrupt is accepted only when `irq_i` and `boundary_i` are both high, status bit 4 (bit 0 of S1) is 1, and the unit is idle. A request that fails any of these leaves the unit idle.
- R7: An accepted interrupt pushes `next_pc_i`. It then reads addresses 12'hFFD, 12'hFFE and 12'hFFF on three consecutive cycles with `mem_rd_o` high, and loads `pc_o` with {data at FFF, data at FFE, data at FFD}.
- R8: `busy_o` is high from the cycle after a call or interrupt is accepted until the cycle the PC is loaded. Jump, call and interrupt requests made while busy are ignored and cause no PC load.
- R9: While reset is active, `pc_o` is 0 and `pc_load_o`, `push_req_o`, `mem_rd_o` and `busy_o` are all low.
- R10: When a jump or call request and an acceptable interrupt arrive in the same cycle, the jump or call is served and the interrupt is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_i | input | 8 | Status word {S1,S0} |
| ctrl_i | input | 4 | Condition nybble |
| target_i | input | 12 | Branch target address |
| next_pc_i | input | 12 | Address of the next opcode |
| jmp_req_i | input | 1 | Jump request |
| call_req_i | input | 1 | Subroutine call request |
| irq_i | input | 1 | Interrupt request |
| boundary_i | input | 1 | High at an instruction boundary |
| push_ack_i | input | 1 | Stack engine has stored the return address |
| mem_data_i | input | 4 | Vector nybble read data (same cycle) |
| pc_o | output | 12 | New program counter |
| pc_load_o | output | 1 | One-cycle PC load strobe |
| push_req_o | output | 1 | Return address push request |
| push_addr_o | output | 12 | Return address to push |
| mem_rd_o | output | 1 | Vector read strobe |
| mem_addr_o | output | 12 | Vector read address |
| busy_o | output | 1 | Call or interrupt sequence in progress |

## Verification
The hardest situation to reach is a request that lands while a sequence is in flight. This can be a jump issued while the stack engine withholds its ack, or an unconditional jump issued in the middle of the three-cycle vector read. The bench holds `push_ack_i` low for a chosen number of cycles and injects a taken jump both during that wait and during the vector read. It then confirms that the only PC load is the expected one. Every condition nybble is swept against every status byte for jumps, and calls are swept over all condition values with ack delays of zero to three cycles.

// File: rtl/flow_pkg.sv
package flow_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_VEC  = 2'd2
  } flow_state_e;
endpackage

// File: rtl/flow_cond.sv
// Condition evaluator: selects one status bit, forces the top bit to one,
// optionally inverts the result.
module flow_cond #(
  parameter int SW = 8,
  parameter int CW = 4
) (
  input  logic [SW-1:0] status_i,
  input  logic [CW-1:0] ctrl_i,
  output logic          taken_o
);
  localparam int SELW = $clog2(SW);

  logic [SW-1:0]   stat_eff;
  logic [SELW-1:0] sel;

  generate
    for (genvar g = 0; g < SW; g++) begin : g_bit
      if (g == SW - 1) begin : g_one
        assign stat_eff[g] = 1'b1;
      end else begin : g_pass
        assign stat_eff[g] = status_i[g];
      end
    end
  endgenerate

  assign sel     = ctrl_i[SELW-1:0];
  assign taken_o = stat_eff[sel] ^ ctrl_i[CW-1];
endmodule

// File: rtl/flow_vec.sv
// Vector fetch: reads NYB nybbles from the top of memory, low nybble first.
module flow_vec #(
  parameter int AW = 12,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [DW-1:0] mem_data_i,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          done_o,
  output logic [AW-1:0] vec_o
);
  localparam int NYB = AW / DW;
  localparam int IW  = (NYB > 1) ? $clog2(NYB) : 1;
  localparam logic [AW-1:0] VEC_BASE = {AW{1'b1}} - AW'(NYB - 1);

  logic          active_q, active_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [DW-1:0] nyb_q [NYB-1];

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    if (start_i) begin
      active_d = 1'b1;
      idx_d    = '0;
    end else if (active_q) begin
      if (idx_q == IW'(NYB - 1)) begin
        active_d = 1'b0;
        idx_d    = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
    end
  end

  generate
    for (genvar g = 0; g < NYB - 1; g++) begin : g_nyb
      logic cap_en;
      assign cap_en = active_q && (idx_q == IW'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      nyb_q[g] <= '0;
        else if (cap_en) nyb_q[g] <= mem_data_i;
      end
      assign vec_o[g*DW +: DW] = nyb_q[g];
    end
  endgenerate

  assign vec_o[(NYB-1)*DW +: DW] = mem_data_i;
  assign mem_rd_o   = active_q;
  assign mem_addr_o = VEC_BASE + AW'(idx_q);
  assign done_o     = active_q && (idx_q == IW'(NYB - 1));
endmodule

// File: rtl/flow_unit.sv
// Top: branch decision, call/interrupt sequencing, PC load.
module flow_unit #(
  parameter int AW = 12,
  parameter int DW = 4,
  parameter int SW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] status_i,
  input  logic [CW-1:0] ctrl_i,
  input  logic [AW-1:0] target_i,
  input  logic [AW-1:0] next_pc_i,
  input  logic          jmp_req_i,
  input  logic          call_req_i,
  input  logic          irq_i,
  input  logic          boundary_i,
  input  logic          push_ack_i,
  input  logic [DW-1:0] mem_data_i,
  output logic [AW-1:0] pc_o,
  output logic          pc_load_o,
  output logic          push_req_o,
  output logic [AW-1:0] push_addr_o,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          busy_o
);
  import flow_pkg::*;

  localparam int IE_BIT = SW / 2;

  logic [1:0]  rsync_q;
  logic        rst_sn;
  flow_state_e state_q, state_d;
  logic [AW-1:0] pc_q, pc_d, tgt_q, tgt_d, ret_q, ret_d;
  logic        load_q, load_d;
  logic        irq_q, irq_d;
  logic        taken, idle, irq_ok, vec_start, vec_done;
  logic [AW-1:0] vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  flow_cond #(.SW(SW), .CW(CW)) u_cond (
    .status_i (status_i),
    .ctrl_i   (ctrl_i),
    .taken_o  (taken)
  );

  flow_vec #(.AW(AW), .DW(DW)) u_vec (
    .clk        (clk),
    .rst_n      (rst_sn),
    .start_i    (vec_start),
    .mem_data_i (mem_data_i),
    .mem_rd_o   (mem_rd_o),
    .mem_addr_o (mem_addr_o),
    .done_o     (vec_done),
    .vec_o      (vec)
  );

  assign idle   = (state_q == ST_IDLE);
  assign irq_ok = idle && irq_i && boundary_i && status_i[IE_BIT]
                  && !jmp_req_i && !call_req_i;

  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    tgt_d     = tgt_q;
    ret_d     = ret_q;
    irq_d     = irq_q;
    load_d    = 1'b0;
    vec_start = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (jmp_req_i) begin
          if (taken) begin
            pc_d   = target_i;
            load_d = 1'b1;
          end
        end else if (call_req_i) begin
          if (taken) begin
            state_d = ST_PUSH;
            tgt_d   = target_i;
            ret_d   = next_pc_i;
            irq_d   = 1'b0;
          end
        end else if (irq_ok) begin
          state_d = ST_PUSH;
          ret_d   = next_pc_i;
          irq_d   = 1'b1;
        end
      end
      ST_PUSH: begin
        if (push_ack_i) begin
          if (irq_q) begin
            state_d   = ST_VEC;
            vec_start = 1'b1;
          end else begin
            state_d = ST_IDLE;
            pc_d    = tgt_q;
            load_d  = 1'b1;
          end
        end
      end
      ST_VEC: begin
        if (vec_done) begin
          state_d = ST_IDLE;
          pc_d    = vec;
          load_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      tgt_q   <= '0;
      ret_q   <= '0;
      irq_q   <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      tgt_q   <= tgt_d;
      ret_q   <= ret_d;
      irq_q   <= irq_d;
      load_q  <= load_d;
    end
  end

  assign pc_o        = pc_q;
  assign pc_load_o   = load_q;
  assign push_req_o  = (state_q == ST_PUSH);
  assign push_addr_o = ret_q;
  assign busy_o      = !idle;
endmodule

// File: rtl/flow_unit_chk.sv
module flow_unit_chk #(
  parameter int AW = 12,
  parameter int DW = 4,
  parameter int SW = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_sn,
  input logic [SW-1:0] status_i,
  input logic [CW-1:0] ctrl_i,
  input logic [AW-1:0] target_i,
  input logic          jmp_req_i,
  input logic          call_req_i,
  input logic          irq_i,
  input logic          boundary_i,
  input logic          push_ack_i,
  input logic [AW-1:0] pc_o,
  input logic          pc_load_o,
  input logic          push_req_o,
  input logic [AW-1:0] push_addr_o,
  input logic          mem_rd_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          busy_o
);
  localparam int NYB  = AW / DW;
  localparam int SELW = $clog2(SW);
  localparam int IE_BIT = SW / 2;
  localparam logic [CW-1:0] ALWAYS = {1'b0, {SELW{1'b1}}};
  localparam logic [AW-1:0] VEC_BASE = {AW{1'b1}} - AW'(NYB - 1);

  assert_always_jump_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (jmp_req_i && !busy_o && ctrl_i == ALWAYS)
      |=> (pc_load_o && pc_o == $past(target_i)));

  assert_push_held_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (push_req_o && !push_ack_i) |=> (push_req_o && $stable(push_addr_o)));

  assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    (!busy_o && !jmp_req_i && !call_req_i && (!status_i[IE_BIT] || !boundary_i))
      |=> !busy_o);

  assert_vec_addr_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_rd_o |-> (busy_o && mem_addr_o >= VEC_BASE && !push_req_o));

  assert_no_load_wait_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    (push_req_o && !push_ack_i) |=> !pc_load_o);

  assert_jump_first_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    (!busy_o && jmp_req_i) |=> !push_req_o);

  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0({push_req_o, mem_rd_o, pc_load_o}));
endmodule

bind flow_unit flow_unit_chk #(.AW(AW), .DW(DW), .SW(SW), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_sn      (rst_sn),
  .status_i    (status_i),
  .ctrl_i      (ctrl_i),
  .target_i    (target_i),
  .jmp_req_i   (jmp_req_i),
  .call_req_i  (call_req_i),
  .irq_i       (irq_i),
  .boundary_i  (boundary_i),
  .push_ack_i  (push_ack_i),
  .pc_o        (pc_o),
  .pc_load_o   (pc_load_o),
  .push_req_o  (push_req_o),
  .push_addr_o (push_addr_o),
  .mem_rd_o    (mem_rd_o),
  .mem_addr_o  (mem_addr_o),
  .busy_o      (busy_o)
);

// File: tb/flow_unit_tb.sv
`timescale 1ns/1ps
module flow_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  status;
  logic [3:0]  ctrl;
  logic [11:0] target, next_pc;
  logic        jmp_req, call_req, irq, boundary, push_ack;
  logic [3:0]  mem_data;
  logic [11:0] pc, push_addr, mem_addr;
  logic        pc_load, push_req, mem_rd, busy;
  logic [3:0]  vmem [3];
  logic [11:0] prev_pc;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  always_comb begin
    case (mem_addr)
      12'hFFD: mem_data = vmem[0];
      12'hFFE: mem_data = vmem[1];
      12'hFFF: mem_data = vmem[2];
      default: mem_data = 4'h0;
    endcase
  end

  flow_unit u_dut (
    .clk(clk), .rst_n(rst_n), .status_i(status), .ctrl_i(ctrl),
    .target_i(target), .next_pc_i(next_pc), .jmp_req_i(jmp_req),
    .call_req_i(call_req), .irq_i(irq), .boundary_i(boundary),
    .push_ack_i(push_ack), .mem_data_i(mem_data), .pc_o(pc),
    .pc_load_o(pc_load), .push_req_o(push_req), .push_addr_o(push_addr),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .busy_o(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_taken(input logic [3:0] c, input logic [7:0] s);
    logic [7:0] st;
    st = s;
    st[7] = 1'b1;
    return st[c[2:0]] ^ c[3];
  endfunction

  task automatic do_jump(input logic [3:0] c, input logic [7:0] s, input logic [11:0] t);
    bit tk;
    string req;
    tk = exp_taken(c, s);
    req = (c[2:0] == 3'd7) ? "R3" : (c[3] ? "R2" : "R1");
    status = s; ctrl = c; target = t; jmp_req = 1'b1;
    @(negedge clk);
    jmp_req = 1'b0;
    check(pc_load == tk, req, int'(pc_load), int'(tk));
    if (tk) prev_pc = t;
    check(pc == prev_pc && !push_req && !busy, "R4", int'(pc), int'(prev_pc));
  endtask

  task automatic do_call(input logic [3:0] c, input logic [7:0] s, input logic [11:0] t,
                         input logic [11:0] npc, input int d);
    bit tk;
    tk = exp_taken(c, s);
    status = s; ctrl = c; target = t; next_pc = npc; call_req = 1'b1;
    @(negedge clk);
    call_req = 1'b0;
    next_pc = ~npc;
    if (tk) begin
      check(push_req && push_addr == npc, "R5", int'(push_addr), int'(npc));
      check(busy == 1'b1, "R8", int'(busy), 1);
      for (int i = 0; i < d; i++) begin
        @(negedge clk);
        check(push_req && !pc_load && push_addr == npc, "R5", int'(push_req), 1);
      end
      push_ack = 1'b1;
      @(negedge clk);
      push_ack = 1'b0;
      check(pc_load && pc == t && !busy, "R5", int'(pc), int'(t));
      prev_pc = t;
    end else begin
      check(!push_req && !busy && !pc_load, "R5", int'(push_req), 0);
    end
  endtask

  task automatic do_irq(input logic [7:0] s, input bit bnd, input logic [11:0] npc,
                        input logic [11:0] vec, input bit inject);
    bit acc;
    acc = bnd && s[4];
    vmem[0] = vec[3:0]; vmem[1] = vec[7:4]; vmem[2] = vec[11:8];
    status = s; next_pc = npc; irq = 1'b1; boundary = bnd;
    @(negedge clk);
    irq = 1'b0; boundary = 1'b0;
    if (!acc) begin
      check(!busy && !push_req && !pc_load, "R6", int'(busy), 0);
      return;
    end
    check(push_req && push_addr == npc && busy, "R7", int'(push_addr), int'(npc));
    if (inject) begin
      ctrl = 4'b0111; target = 12'h123; jmp_req = 1'b1; irq = 1'b1; boundary = 1'b1;
      @(negedge clk);
      jmp_req = 1'b0; irq = 1'b0; boundary = 1'b0;
      check(push_req && !pc_load && push_addr == npc, "R8", int'(pc_load), 0);
    end
    push_ack = 1'b1;
    @(negedge clk);
    push_ack = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check(mem_rd && mem_addr == 12'hFFD + 12'(k), "R7", int'(mem_addr), 12'hFFD + k);
      if (inject && k == 1) begin
        ctrl = 4'b0111; target = 12'h456; jmp_req = 1'b1;
      end
      @(negedge clk);
      jmp_req = 1'b0;
    end
    check(pc_load && pc == vec && !busy, "R7", int'(pc), int'(vec));
    prev_pc = vec;
    @(negedge clk);
    check(!pc_load && pc == vec, "R8", int'(pc), int'(vec));
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL R8 watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; status = '0; ctrl = '0; target = '0; next_pc = '0;
    jmp_req = 0; call_req = 0; irq = 0; boundary = 0; push_ack = 0;
    vmem[0] = '0; vmem[1] = '0; vmem[2] = '0;
    prev_pc = '0;
    repeat (3) @(negedge clk);
    check(pc == 12'h0 && !pc_load && !push_req && !mem_rd && !busy, "R9", int'(pc), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R2 R3 R4: every condition nybble against every status byte
    for (int c = 0; c < 16; c++) begin
      for (int s = 0; s < 256; s++) begin
        do_jump(4'(c), 8'(s), 12'(c * 256 + s) ^ 12'hA5A);
      end
    end

    // R5: calls with varied ack delay
    for (int c = 0; c < 16; c++) begin
      do_call(4'(c), 8'h00, 12'(12'h300 + c), 12'(12'h700 + c), c % 4);
      do_call(4'(c), 8'hFF, 12'(12'h310 + c), 12'(12'h710 + c), (c + 1) % 4);
      do_call(4'(c), 8'h5A, 12'(12'h320 + c), 12'(12'h720 + c), (c + 2) % 4);
      do_call(4'(c), 8'hA5, 12'(12'h330 + c), 12'(12'h730 + c), (c + 3) % 4);
    end

    // R6: masked by enable bit, and outside a boundary
    do_irq(8'hEF, 1'b1, 12'h111, 12'hBCD, 1'b0);
    do_irq(8'h10, 1'b0, 12'h111, 12'hBCD, 1'b0);
    // R7: accepted interrupts with assorted vectors
    do_irq(8'h10, 1'b1, 12'h222, 12'hBCD, 1'b0);
    do_irq(8'hFF, 1'b1, 12'h9A0, 12'h001, 1'b0);
    do_irq(8'h30, 1'b1, 12'hFFE, 12'hF0E, 1'b0);
    // R8: requests during a sequence are ignored
    do_irq(8'h10, 1'b1, 12'h345, 12'h6E7, 1'b1);

    // R10: taken jump together with an acceptable interrupt
    status = 8'h10; ctrl = 4'b0111; target = 12'h5C3; jmp_req = 1'b1;
    irq = 1'b1; boundary = 1'b1;
    @(negedge clk);
    jmp_req = 1'b0; irq = 1'b0; boundary = 1'b0;
    check(pc_load && pc == 12'h5C3 && !busy && !push_req, "R10", int'(pc), 12'h5C3);
    // R10: untaken call with interrupt still drops the interrupt
    ctrl = 4'b1111; call_req = 1'b1; irq = 1'b1; boundary = 1'b1;
    @(negedge clk);
    call_req = 1'b0; irq = 1'b0; boundary = 1'b0;
    check(!busy && !push_req, "R10", int'(busy), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule